// File: doc/BRIEF.md
# Iterative SIMD Multiply-Accumulate Unit

This block is a signed multiply-accumulate datapath with two 40-bit accumulators. Operations enter through a valid/ready issue port that carries an opcode, a 32-bit multiplicand, a 32-bit multiplier and an accumulator select. Each operation flows through four registered stages: issue, multiply, align and accumulate. The running sum is read back through a combinational read port that can address either accumulator.

The multiplier operand is retired in slices. The first pass takes 16 bits and every later pass takes 12 bits. A halfword multiplier is therefore finished in one pass and issues at one operation per clock. A full 32-bit multiplier needs three passes: 16 bits, then 12 bits, then the top 4 bits as a signed slice. During those passes the issue port holds ready low. A dual mode forms two signed 16x16 halfword products and adds both of them to one accumulator.

The sum is added into the accumulator in the last stage, in issue order. Because of this, back-to-back operations on the same accumulator never read a stale value and never need to stall. The accumulators keep eight guard bits above 32 and wrap modulo 2^40. They do not saturate.

Back-pressure rules for the issue port:
- An operation is taken on a rising edge where both in_valid and in_ready are high.
- in_ready depends only on the iteration state, never on in_valid.
- While in_ready is low, the values on the issue inputs are ignored.

Top module: `simd_mac_unit`

## Requirements
- R1: A synchronous reset clears both accumulators to zero, discards any operation in flight, and leaves in_ready high.
- R2: Opcode 00 adds the signed 32x32 product of in_mcand and in_mplier to the selected accumulator. The complete sum is visible on rd_data after the fifth rising edge following acceptance.
- R3: After an opcode 00 operation is accepted, in_ready is low for the next two cycles and high again in the third.
- R4: Opcode 01 adds the product of signed in_mcand and the signed low halfword in_mplier[15:0]. It leaves in_ready high, so one such operation is taken per clock. Its result shows on rd_data after the third rising edge following acceptance and not after the second.
- R5: Opcode 10 adds in_mcand[15:0]*in_mplier[15:0] + in_mcand[31:16]*in_mplier[31:16], with every halfword signed, to the selected accumulator.
- R6: Opcode 11 sets the selected accumulator to zero, visible after the third rising edge following acceptance.
- R7: in_acc_sel=0 targets the first accumulator and 1 the second, and rd_sel uses the same encoding. An operation never changes the unselected accumulator.
- R8: Accumulation wraps modulo 2^40 with no saturation.
- R9: Operations issued on consecutive cycles, including ones to the same accumulator, are all applied in order with none lost.
- R10: An operation presented while in_ready is low is not taken and has no effect on either accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue request |
| in_ready | output | 1 | Issue port can take an operation |
| in_op | input | 2 | Opcode: 00 mac32, 01 mac16, 10 dual16, 11 clear |
| in_acc_sel | input | 1 | Target accumulator |
| in_mcand | input | 32 | Signed multiplicand |
| in_mplier | input | 32 | Signed multiplier (or two halfwords) |
| rd_sel | input | 1 | Accumulator shown on rd_data |
| rd_data | output | 40 | Selected accumulator value |

## Verification
The due cycles are counted from the acceptance edge:
- A single-pass operation (01, 10, 11) lands in its accumulator on the third rising edge after acceptance.
- A 32x32 operation lands on the fifth rising edge, because its last slice is issued two edges later than its first.

The bench drives inputs at falling edges and counts falling edges after each acceptance. It samples rd_data exactly one falling edge before the due edge and again right after it. For the sweeps, the bench drains six cycles, which is past every due point, before it compares both accumulators with an arithmetic model. The stall window is checked by sampling in_ready at the falling edges after acceptance, while a competing request is held on the port.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OPW   = 32;               // operand width
  localparam int ACCW  = 40;               // accumulator width
  localparam int FIRST = 16;               // multiplier bits in pass one
  localparam int NEXT  = 12;               // multiplier bits in later passes
  localparam int NACC  = 2;                // accumulator count
  localparam int ITERS = 1 + (OPW - FIRST + NEXT - 1) / NEXT;
  localparam int CHW   = FIRST + 1;        // signed slice width
  localparam int CNTW  = $clog2(ITERS);
  localparam int SHW   = $clog2(OPW);
  localparam int SELW  = $clog2(NACC);
  localparam int HALF  = OPW / 2;

  typedef enum logic [1:0] {
    OP_MAC32 = 2'b00,
    OP_MAC16 = 2'b01,
    OP_DUAL  = 2'b10,
    OP_CLR   = 2'b11
  } mac_op_e;

  typedef struct packed {
    logic            vld;
    mac_op_e         op;
    logic [SELW-1:0] sel;
    logic [OPW-1:0]  a;
    logic [OPW-1:0]  b;
    logic [CHW-1:0]  chunk;
    logic [SHW-1:0]  shamt;
  } slice_t;
endpackage

// File: rtl/mac_issue.sv
module mac_issue
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [SELW-1:0]  in_sel,
  input  logic [OPW-1:0]   in_a,
  input  logic [OPW-1:0]   in_b,
  output logic             in_ready,
  output slice_t           s1
);
  logic [CNTW-1:0] cnt;
  logic [OPW-1:0]  ha, hb;
  logic [SELW-1:0] hsel;
  slice_t          nxt;
  int              start;

  assign in_ready = (cnt == '0);

  always_comb begin
    nxt   = '0;
    start = FIRST + (int'(cnt) - 1) * NEXT;
    if (cnt == '0) begin
      nxt.vld   = in_valid;
      nxt.op    = mac_op_e'(in_op);
      nxt.sel   = in_sel;
      nxt.a     = in_a;
      nxt.b     = in_b;
      nxt.shamt = '0;
      if (mac_op_e'(in_op) == OP_MAC32)
        nxt.chunk = {1'b0, in_b[FIRST-1:0]};
      else
        nxt.chunk = {in_b[FIRST-1], in_b[FIRST-1:0]};
    end else begin
      nxt.vld   = 1'b1;
      nxt.op    = OP_MAC32;
      nxt.sel   = hsel;
      nxt.a     = ha;
      nxt.b     = hb;
      nxt.shamt = SHW'(start);
      if (cnt == CNTW'(ITERS - 1))
        nxt.chunk = CHW'($signed(hb) >>> start);
      else
        nxt.chunk = CHW'((hb >> start) & ((OPW'(1) << NEXT) - OPW'(1)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      ha   <= '0;
      hb   <= '0;
      hsel <= '0;
      s1   <= '0;
    end else begin
      s1 <= nxt;
      if (cnt == '0) begin
        if (in_valid && mac_op_e'(in_op) == OP_MAC32) begin
          cnt  <= CNTW'(1);
          ha   <= in_a;
          hb   <= in_b;
          hsel <= in_sel;
        end
      end else if (cnt == CNTW'(ITERS - 1)) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + CNTW'(1);
      end
    end
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  slice_t           s1,
  output logic             t_vld,
  output logic             t_clr,
  output logic [SELW-1:0]  t_sel,
  output logic [ACCW-1:0]  t_val
);
  logic                   p_vld;
  mac_op_e                p_op;
  logic [SELW-1:0]        p_sel;
  logic [SHW-1:0]         p_shamt;
  logic [ACCW-1:0]        p_main;
  logic signed [OPW-1:0]  p_lo, p_hi;
  logic [ACCW-1:0]        aligned;

  // multiply stage
  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld   <= 1'b0;
      p_op    <= OP_MAC32;
      p_sel   <= '0;
      p_shamt <= '0;
      p_main  <= '0;
      p_lo    <= '0;
      p_hi    <= '0;
    end else begin
      p_vld   <= s1.vld;
      p_op    <= s1.op;
      p_sel   <= s1.sel;
      p_shamt <= s1.shamt;
      p_main  <= ACCW'($signed(s1.a)) * ACCW'($signed(s1.chunk));
      p_lo    <= OPW'($signed(s1.a[HALF-1:0])) * OPW'($signed(s1.b[HALF-1:0]));
      p_hi    <= OPW'($signed(s1.a[OPW-1:HALF])) * OPW'($signed(s1.b[OPW-1:HALF]));
    end
  end

  always_comb begin
    case (p_op)
      OP_DUAL: aligned = ACCW'(p_lo) + ACCW'(p_hi);
      OP_CLR:  aligned = '0;
      default: aligned = p_main << p_shamt;
    endcase
  end

  // align stage
  always_ff @(posedge clk) begin
    if (rst) begin
      t_vld <= 1'b0;
      t_clr <= 1'b0;
      t_sel <= '0;
      t_val <= '0;
    end else begin
      t_vld <= p_vld;
      t_clr <= (p_op == OP_CLR);
      t_sel <= p_sel;
      t_val <= aligned;
    end
  end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             t_vld,
  input  logic             t_clr,
  input  logic [SELW-1:0]  t_sel,
  input  logic [ACCW-1:0]  t_val,
  input  logic [SELW-1:0]  rd_sel,
  output logic [ACCW-1:0]  rd_data
);
  logic [ACCW-1:0] acc [NACC];

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)
        acc[g] <= '0;
      else if (t_vld && int'(t_sel) == g)
        acc[g] <= t_clr ? '0 : acc[g] + t_val;
    end
  end

  assign rd_data = acc[rd_sel];
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  in_op,
  input  logic        in_acc_sel,
  input  logic [31:0] in_mcand,
  input  logic [31:0] in_mplier,
  input  logic        rd_sel,
  output logic [39:0] rd_data
);
  slice_t          s1;
  logic            t_vld, t_clr;
  logic [SELW-1:0] t_sel;
  logic [ACCW-1:0] t_val;

  mac_issue u_issue (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_sel(in_acc_sel), .in_a(in_mcand), .in_b(in_mplier),
    .in_ready(in_ready), .s1(s1)
  );

  mac_mult u_mult (
    .clk(clk), .rst(rst), .s1(s1),
    .t_vld(t_vld), .t_clr(t_clr), .t_sel(t_sel), .t_val(t_val)
  );

  mac_acc_bank u_bank (
    .clk(clk), .rst(rst), .t_vld(t_vld), .t_clr(t_clr),
    .t_sel(t_sel), .t_val(t_val), .rd_sel(rd_sel), .rd_data(rd_data)
  );
endmodule

// File: rtl/mac_checker.sv
module mac_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_op,
  input logic        in_acc_sel,
  input logic        rd_sel,
  input logic [39:0] rd_data
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (in_ready && rd_data == 40'd0));

  assert_mac32_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 2'b00) |=> !in_ready ##1 !in_ready ##1 in_ready);

  assert_single_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op != 2'b00) |=> in_ready);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 2'b11 && in_acc_sel == 1'b0)
      |-> ##4 (rd_sel != 1'b0 || rd_data == 40'd0));
endmodule

bind simd_mac_unit mac_checker u_mac_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_acc_sel(in_acc_sel), .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/test_simd_mac_unit.sv
module test_simd_mac_unit;
  logic        clk, rst, in_valid, in_ready, in_acc_sel, rd_sel;
  logic [1:0]  in_op;
  logic [31:0] in_mcand, in_mplier;
  logic [39:0] rd_data;
  logic [39:0] m_acc [2];
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  localparam logic [31:0] VALS [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h00007FFF,
                                       32'hFFFF8000, 32'h7FFFFFFF, 32'h80000000, 32'h9ABC1234};

  simd_mac_unit i_simd_mac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc_sel(in_acc_sel), .in_mcand(in_mcand),
    .in_mplier(in_mplier), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [39:0] term_of(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    longint x, y, u, v, p;
    case (op)
      2'b00: begin x = $signed(a); y = $signed(b); p = x * y; end
      2'b01: begin x = $signed(a); y = $signed(b[15:0]); p = x * y; end
      2'b10: begin
        x = $signed(a[15:0]);  y = $signed(b[15:0]);
        u = $signed(a[31:16]); v = $signed(b[31:16]);
        p = x * y + u * v;
      end
      default: p = 0;
    endcase
    return p[39:0];
  endfunction

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic sel, logic [31:0] a, logic [31:0] b);
    in_valid = 1; in_op = op; in_acc_sel = sel; in_mcand = a; in_mplier = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    if (op == 2'b11) m_acc[sel] = '0;
    else m_acc[sel] = m_acc[sel] + term_of(op, a, b);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  task automatic check_both(string req);
    rd_sel = 0; #1; chk(req, rd_data, m_acc[0]);
    rd_sel = 1; #1; chk(req, rd_data, m_acc[1]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1; in_valid = 0; in_op = 0; in_acc_sel = 0; in_mcand = 0; in_mplier = 0; rd_sel = 0;
    m_acc[0] = '0; m_acc[1] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 40'(in_ready), 40'd1);
    check_both("R1 accumulators");

    // sweeps over ops 00 (R2), 01 (R4), 10 (R5); other accumulator unchanged (R7)
    for (int op = 0; op < 3; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          issue(2'(op), 1'((i + j) % 2), VALS[i], VALS[j]);
          drain();
          check_both(op == 0 ? "R2/R7 sweep" : (op == 1 ? "R4/R7 sweep" : "R5/R7 sweep"));
        end

    // R6 clear each accumulator, the other one stays (R7)
    issue(2'b11, 1'b0, 32'h5, 32'h5);
    drain(); check_both("R6 clear acc0");
    issue(2'b11, 1'b1, 32'h5, 32'h5);
    drain(); check_both("R6 clear acc1");

    // R4 latency: result after third edge, not second
    issue(2'b01, 1'b0, 32'd3, 32'hABCD0005);
    rd_sel = 0;
    @(negedge clk); @(negedge clk);
    chk("R4 not before third edge", rd_data, 40'd0);
    @(negedge clk);
    chk("R4 after third edge", rd_data, 40'd15);

    // R2 latency and R3 stall
    issue(2'b00, 1'b1, 32'd3, 32'h10010001);
    rd_sel = 1;
    chk("R3 ready low 1", 40'(in_ready), 40'd0);
    @(negedge clk);
    chk("R3 ready low 2", 40'(in_ready), 40'd0);
    @(negedge clk);
    chk("R3 ready back", 40'(in_ready), 40'd1);
    @(negedge clk); @(negedge clk);
    chk("R2 not complete before fifth edge", 40'(rd_data != 40'h30030003), 40'd1);
    @(negedge clk);
    chk("R2 complete after fifth edge", rd_data, 40'h30030003);
    drain();

    // R10 request held during the stall is ignored
    issue(2'b00, 1'b0, 32'h1234, 32'hFEDCBA98);
    in_valid = 1; in_op = 2'b01; in_acc_sel = 1'b1; in_mcand = 32'd7; in_mplier = 32'd7;
    chk("R10 stall 1", 40'(in_ready), 40'd0);
    @(negedge clk);
    chk("R10 stall 2", 40'(in_ready), 40'd0);
    @(negedge clk);
    in_valid = 0;
    drain(); check_both("R10 ignored");

    // R8 wrap modulo 2^40
    issue(2'b11, 1'b0, 0, 0);
    for (int k = 0; k < 6; k++) issue(2'b00, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF);
    drain(); check_both("R8 wrap");

    // R9 back-to-back burst, R4 one per clock
    for (int k = 0; k < 24; k++) begin
      issue(2'(k % 3 == 2 ? 2 : 1), 1'(k % 4 == 0), VALS[k % 8], VALS[(k * 3 + 1) % 8]);
      if (k % 3 != 2) begin in_valid = 1; in_op = 2'b01; end
      if (k % 3 != 2) chk("R4 ready held", 40'(in_ready), 40'd1);
      in_valid = 0;
    end
    issue(2'b00, 1'b0, 32'h9ABC1234, 32'h80000001);
    issue(2'b01, 1'b0, 32'hFFFFFFFF, 32'h00008000);
    issue(2'b10, 1'b0, 32'h7FFF8000, 32'h80007FFF);
    drain(); check_both("R9 burst");

    finish_run();
  end
endmodule